// File: doc/BRIEF.md
# Mode-Switched Global Crossbar Network

This block is the global point-to-point network of a SIMD processor array. It links one array controller, `N_PE` processing elements (PEs), one input device and one output device through a non-blocking crossbar. A mode register, written by the controller at a fixed address, selects the traffic pattern. In the addressed modes a PE names its partner inside the access address. In the device modes the partner is implied by the mode and the address holds only a local offset.

Each PE drives one memory-mapped access per cycle: a send (write) or a receive (read). Every PE owns a one-word inbox that point-to-point and controller traffic lands in. For the broadcast-read mode, every PE also owns a broadcast slot that any number of PEs may read at once. Accesses are acknowledged by a combinational ready signal, and receive data is valid in the same cycle as that ready. Requests that cannot complete are stalled by holding ready low. `N_PE` must be a power of two.

Top module: `gnoc_xbar`

## Requirements
- R1: After reset the mode is 0 (PE to PE) and every inbox and broadcast slot is empty, so a receive issued right after reset is stalled.
- R2: A controller access to `MODE_ADDR` (default 0x9003) is acknowledged in the same cycle. A data value 0 to 4 becomes the mode from the next cycle on. Any larger value leaves the mode unchanged. A mode write takes precedence over a controller send to the same address.
- R3: In mode 0, the partner identifier of a PE access sits in address bits `[OFS_W +: log2(N_PE)]`, and the bits below are ignored. A send completes when the target inbox is empty, or when it is being emptied in the same cycle. A receive naming source s completes when its inbox holds a word from PE s, and it returns that word on `pe_rdata` in the same cycle.
- R4: When several PEs send to one destination in the same cycle, the lowest-numbered PE is accepted and the others see ready low.
- R5: A receive with no matching word is stalled. This includes an inbox that holds a word from a different source.
- R6: Sends from different PEs to distinct destinations all complete in the same cycle.
- R7: In mode 1 the controller sends to the PE named in `ctl_addr[OFS_W +: log2(N_PE)]`, and it is stalled while that inbox is full and not being emptied. A PE receive ignores its identifier and takes only a word from the controller.
- R8: In mode 2 any PE receive raises `in_ready`. The lowest-numbered receiving PE takes `in_data` when `in_valid` is high. Every other receiver is stalled.
- R9: In mode 3 any PE send raises `out_valid` and carries the data of the lowest-numbered sender. That sender completes when `out_ready` is high, and the others are stalled.
- R10: In mode 4 a PE send always completes and overwrites the sender's broadcast slot. A receive naming PE t returns slot t without emptying it, so several readers may complete in the same cycle. The receive is stalled until slot t has been written at least once since reset.
- R11: An access with no meaning in the current mode completes at once and is discarded, and a discarded receive returns zero. These are: a PE send in modes 1 and 2, a PE receive in mode 3, and a controller access other than a mode write outside mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Controller access request |
| ctl_addr | input | ADDR_W | Controller address (mode register or PE identifier field) |
| ctl_wdata | input | DATA_W | Controller write data |
| ctl_ready | output | 1 | Controller access completes this cycle |
| pe_valid | input | N_PE | Per-PE access request |
| pe_write | input | N_PE | Per-PE access kind: 1 send, 0 receive |
| pe_addr | input | N_PE*ADDR_W | Per-PE address, PE s in slice s |
| pe_wdata | input | N_PE*DATA_W | Per-PE send data |
| pe_ready | output | N_PE | Per-PE access completes this cycle |
| pe_rdata | output | N_PE*DATA_W | Per-PE receive data, valid with ready |
| in_valid | input | 1 | Input device offers a word |
| in_data | input | DATA_W | Input device word |
| in_ready | output | 1 | A PE is taking the input word |
| out_valid | output | 1 | A word is offered to the output device |
| out_data | output | DATA_W | Word for the output device |
| out_ready | input | 1 | Output device accepts the word |

## Verification
Directed sequences first separate the cases that differ only in their timing. A lone send followed by a receive is compared with a receive issued before any send. Two senders aiming at one inbox are compared with a drain and a refill in the same cycle. All PEs sending to distinct neighbours in one cycle tests that distinct pairs do not block each other. Each mode is then driven with several hundred cycles of unconstrained random requests. A behavioural model in the bench predicts every ready, data and device handshake on each cycle. This exposes wrong arbitration order, wrong field decoding, lost or duplicated inbox words, broadcast reads that consume their slot, and accesses that should have been discarded but were acted on.

// File: rtl/gnoc_pkg.sv
`timescale 1ns/1ps
package gnoc_pkg;

  // Connection pattern chosen by the mode register
  typedef enum logic [2:0] {
    M_P2P    = 3'd0,  // PE to PE, partner named in address
    M_CTL    = 3'd1,  // controller to PE
    M_INDEV  = 3'd2,  // input device to PE
    M_OUTDEV = 3'd3,  // PE to output device
    M_BCAST  = 3'd4   // PE to PE broadcast-read
  } gnoc_mode_e;

  localparam int unsigned MODE_COUNT = 5;

endpackage

// File: rtl/gnoc_mode_reg.sv
`timescale 1ns/1ps
module gnoc_mode_reg
  import gnoc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h9003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output gnoc_mode_e        mode,
  output logic              hit
);

  gnoc_mode_e mode_q, mode_d;
  logic       legal;

  assign hit   = wr_valid && (wr_addr == MODE_ADDR);
  assign legal = (wr_data < DATA_W'(MODE_COUNT));

  always_comb begin
    mode_d = mode_q;
    if (hit && legal) mode_d = gnoc_mode_e'(wr_data[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_P2P;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= M_BCAST);

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_addr == MODE_ADDR) |=> $stable(mode_q));

endmodule

// File: rtl/gnoc_fixed_arb.sv
`timescale 1ns/1ps
module gnoc_fixed_arb #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] gnt
);

  // isolate the lowest set request bit
  assign gnt = req & (~req + W'(1));

endmodule

// File: rtl/gnoc_mailbox.sv
`timescale 1ns/1ps
module gnoc_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ctl,
  input  logic [ID_W-1:0]   load_src,
  input  logic              drain,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              from_ctl,
  output logic [ID_W-1:0]   src
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              ctl_q;
  logic [ID_W-1:0]   src_q;

  always_comb begin
    full_d = full_q;
    if (drain) full_d = 1'b0;
    if (load)  full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= load_data;
      ctl_q  <= load_ctl;
      src_q  <= load_src;
    end
  end

  assign full     = full_q;
  assign data     = data_q;
  assign from_ctl = ctl_q;
  assign src      = src_q;

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!full_q || drain));

  assert_drain_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> full_q);

endmodule

// File: rtl/gnoc_xbar.sv
`timescale 1ns/1ps
module gnoc_xbar
  import gnoc_pkg::*;
#(
  parameter int unsigned       N_PE      = 4,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       OFS_W     = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h9003
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_valid,
  input  logic [ADDR_W-1:0]        ctl_addr,
  input  logic [DATA_W-1:0]        ctl_wdata,
  output logic                     ctl_ready,
  input  logic [N_PE-1:0]          pe_valid,
  input  logic [N_PE-1:0]          pe_write,
  input  logic [N_PE*ADDR_W-1:0]   pe_addr,
  input  logic [N_PE*DATA_W-1:0]   pe_wdata,
  output logic [N_PE-1:0]          pe_ready,
  output logic [N_PE*DATA_W-1:0]   pe_rdata,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     out_ready
);

  localparam int unsigned ID_W = (N_PE > 1) ? $clog2(N_PE) : 1;

  // ---------------- mode manager ----------------
  gnoc_mode_e mode;
  logic       mode_hit;

  gnoc_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_valid(ctl_valid), .wr_addr(ctl_addr),
    .wr_data(ctl_wdata), .mode(mode), .hit(mode_hit)
  );

  logic is_p2p, is_ctl, is_in, is_out, is_bc;
  assign is_p2p = (mode == M_P2P);
  assign is_ctl = (mode == M_CTL);
  assign is_in  = (mode == M_INDEV);
  assign is_out = (mode == M_OUTDEV);
  assign is_bc  = (mode == M_BCAST);

  // ---------------- request decode ----------------
  logic [ID_W-1:0]   tid [N_PE];
  logic [DATA_W-1:0] wd  [N_PE];
  logic [N_PE-1:0]   snd, rcv;
  logic              addr_unused;

  for (genvar s = 0; s < N_PE; s++) begin : g_dec
    assign tid[s] = pe_addr[s*ADDR_W + OFS_W +: ID_W];
    assign wd[s]  = pe_wdata[s*DATA_W +: DATA_W];
    assign snd[s] = pe_valid[s] & pe_write[s];
    assign rcv[s] = pe_valid[s] & ~pe_write[s];
  end
  assign addr_unused = ^pe_addr;

  logic            ctl_send;
  logic [ID_W-1:0] ctl_tid;
  assign ctl_send = ctl_valid & ~mode_hit & is_ctl;
  assign ctl_tid  = ctl_addr[OFS_W +: ID_W];

  // ---------------- inboxes ----------------
  logic [N_PE-1:0]   mb_full, mb_ctl, rx_match, drain, load;
  logic [DATA_W-1:0] mb_data [N_PE];
  logic [ID_W-1:0]   mb_src  [N_PE];
  logic [N_PE-1:0]   gnt_m   [N_PE];

  always_comb begin
    for (int s = 0; s < N_PE; s++) begin
      rx_match[s] = mb_full[s] & (is_ctl ? mb_ctl[s]
                                         : (~mb_ctl[s] & (mb_src[s] == tid[s])));
      drain[s]    = rcv[s] & rx_match[s] & (is_p2p | is_ctl);
    end
  end

  for (genvar d = 0; d < N_PE; d++) begin : g_dst
    logic [N_PE-1:0]   req, gnt;
    logic              ctl_here, cap;
    logic [DATA_W-1:0] ld_data;
    logic [ID_W-1:0]   ld_src;

    always_comb begin
      for (int s = 0; s < N_PE; s++)
        req[s] = is_p2p & snd[s] & (tid[s] == ID_W'(d));
    end

    gnoc_fixed_arb #(.W(N_PE)) u_arb (.req(req), .gnt(gnt));
    assign gnt_m[d] = gnt;

    assign ctl_here = ctl_send & (ctl_tid == ID_W'(d));
    assign cap      = ~mb_full[d] | drain[d];
    assign load[d]  = cap & ((|req) | ctl_here);

    always_comb begin
      ld_data = ctl_here ? ctl_wdata : '0;
      ld_src  = '0;
      for (int s = 0; s < N_PE; s++) begin
        if (gnt[s]) begin
          ld_data = wd[s];
          ld_src  = ID_W'(s);
        end
      end
    end

    gnoc_mailbox #(.DATA_W(DATA_W), .ID_W(ID_W)) u_mb (
      .clk(clk), .rst_n(rst_n), .load(load[d]), .load_data(ld_data),
      .load_ctl(ctl_here), .load_src(ld_src), .drain(drain[d]),
      .full(mb_full[d]), .data(mb_data[d]), .from_ctl(mb_ctl[d]), .src(mb_src[d])
    );

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

    assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt - N_PE'(1)) & req) == '0);

    assert_rx_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_p2p && rcv[d] && !mb_full[d]) |-> !pe_ready[d]);
  end

  // ---------------- device ports ----------------
  logic [N_PE-1:0] in_req, in_gnt, out_req, out_gnt;
  assign in_req  = rcv & {N_PE{is_in}};
  assign out_req = snd & {N_PE{is_out}};

  gnoc_fixed_arb #(.W(N_PE)) u_in_arb  (.req(in_req),  .gnt(in_gnt));
  gnoc_fixed_arb #(.W(N_PE)) u_out_arb (.req(out_req), .gnt(out_gnt));

  assign in_ready  = |in_req;
  assign out_valid = |out_req;

  always_comb begin
    out_data = '0;
    for (int s = 0; s < N_PE; s++)
      if (out_gnt[s]) out_data = wd[s];
  end

  // ---------------- broadcast slots ----------------
  logic [N_PE-1:0]   pub_valid_q, pub_valid_d, pub_we;
  logic [DATA_W-1:0] pub_data_q [N_PE];

  assign pub_we      = snd & {N_PE{is_bc}};
  assign pub_valid_d = pub_valid_q | pub_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pub_valid_q <= '0;
    else        pub_valid_q <= pub_valid_d;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < N_PE; s++)
      if (pub_we[s]) pub_data_q[s] <= wd[s];
  end

  // ---------------- responses ----------------
  always_comb begin
    for (int s = 0; s < N_PE; s++) begin
      logic              rdy;
      logic [DATA_W-1:0] rd;
      rdy = 1'b0;
      rd  = '0;
      case (mode)
        M_P2P: begin
          rdy = pe_write[s] ? (gnt_m[tid[s]][s] & load[tid[s]]) : rx_match[s];
          rd  = mb_data[s];
        end
        M_CTL: begin
          rdy = pe_write[s] ? 1'b1 : rx_match[s];
          rd  = mb_data[s];
        end
        M_INDEV: begin
          rdy = pe_write[s] ? 1'b1 : (in_gnt[s] & in_valid);
          rd  = in_data;
        end
        M_OUTDEV: begin
          rdy = pe_write[s] ? (out_gnt[s] & out_ready) : 1'b1;
        end
        M_BCAST: begin
          rdy = pe_write[s] ? 1'b1 : pub_valid_q[tid[s]];
          rd  = pub_data_q[tid[s]];
        end
        default: rdy = 1'b1;
      endcase
      pe_ready[s]                  = pe_valid[s] & rdy;
      pe_rdata[s*DATA_W +: DATA_W] = rd;
    end
  end

  assign ctl_ready = ctl_valid & (mode_hit | ~is_ctl | load[ctl_tid]);

  assert_out_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && |(pe_ready & pe_write)) |-> (out_ready && out_valid));

  assert_in_only_mode2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (mode == M_INDEV));

  assert_ctl_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_send && mb_full[ctl_tid] && !drain[ctl_tid]) |-> !ctl_ready);

endmodule

// File: tb/tb_gnoc_xbar.sv
`timescale 1ns/1ps
module tb_gnoc_xbar;

  localparam int N = 4, DW = 32, AW = 16, OFS = 8, IDW = 2;
  localparam logic [AW-1:0] MA = 16'h9003;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_valid, ctl_ready, in_valid, in_ready, out_valid, out_ready;
  logic [AW-1:0] ctl_addr;
  logic [DW-1:0] ctl_wdata, in_data, out_data;
  logic [N-1:0] pe_valid, pe_write, pe_ready;
  logic [N*AW-1:0] pe_addr;
  logic [N*DW-1:0] pe_wdata, pe_rdata;

  always #4 clk = ~clk;

  gnoc_xbar #(.N_PE(N), .DATA_W(DW), .ADDR_W(AW), .OFS_W(OFS), .MODE_ADDR(MA)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_ready(ctl_ready), .pe_valid(pe_valid),
    .pe_write(pe_write), .pe_addr(pe_addr), .pe_wdata(pe_wdata),
    .pe_ready(pe_ready), .pe_rdata(pe_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state
  int md; bit mfull[N]; int msrc[N]; bit mctl[N]; logic [DW-1:0] mdata[N];
  bit pv[N]; logic [DW-1:0] pd[N];
  int p_mode; bit p_drain[N]; bit p_load[N]; logic [DW-1:0] p_ldd[N];
  int p_lds[N]; bit p_ldc[N]; bit p_pub[N]; logic [DW-1:0] p_pubd[N];

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int tid_of(int s);
    return int'(pe_addr[s*AW + OFS +: IDW]);
  endfunction

  function automatic logic [DW-1:0] wd_of(int s);
    return pe_wdata[s*DW +: DW];
  endfunction

  task automatic eval_check();
    bit er[N]; logic [DW-1:0] erd[N];
    bit ecr, einr, eoutv, hit; logic [DW-1:0] eoutd; int win;
    ecr = 0; einr = 0; eoutv = 0; eoutd = '0; p_mode = md;
    for (int s = 0; s < N; s++) begin
      er[s] = 0; erd[s] = '0; p_drain[s] = 0; p_load[s] = 0; p_pub[s] = 0;
    end
    hit = ctl_valid && (ctl_addr == MA);
    if (hit) begin
      ecr = 1;
      if (ctl_wdata < 5) p_mode = int'(ctl_wdata);
    end else if (ctl_valid && md != 1) ecr = 1;

    if (md == 0 || md == 1) begin
      for (int s = 0; s < N; s++) begin
        if (pe_valid[s] && !pe_write[s]) begin
          bit m;
          m = mfull[s] && ((md == 1) ? mctl[s] : (!mctl[s] && msrc[s] == tid_of(s)));
          er[s] = m; erd[s] = mdata[s]; p_drain[s] = m;
        end
      end
      if (md == 0) begin
        for (int d = 0; d < N; d++) begin
          win = -1;
          for (int s = 0; s < N; s++)
            if (win < 0 && pe_valid[s] && pe_write[s] && tid_of(s) == d) win = s;
          if (win >= 0 && (!mfull[d] || p_drain[d])) begin
            er[win] = 1; p_load[d] = 1; p_ldd[d] = wd_of(win); p_lds[d] = win; p_ldc[d] = 0;
          end
        end
      end else begin
        for (int s = 0; s < N; s++) if (pe_valid[s] && pe_write[s]) er[s] = 1;
        if (ctl_valid && !hit) begin
          int d;
          d = int'(ctl_addr[OFS +: IDW]);
          if (!mfull[d] || p_drain[d]) begin
            ecr = 1; p_load[d] = 1; p_ldd[d] = ctl_wdata; p_lds[d] = 0; p_ldc[d] = 1;
          end
        end
      end
    end else if (md == 2) begin
      win = -1;
      for (int s = 0; s < N; s++) begin
        if (pe_valid[s] && pe_write[s]) er[s] = 1;
        if (win < 0 && pe_valid[s] && !pe_write[s]) win = s;
      end
      einr = (win >= 0);
      if (win >= 0) begin er[win] = in_valid; erd[win] = in_data; end
    end else if (md == 3) begin
      win = -1;
      for (int s = 0; s < N; s++) begin
        if (pe_valid[s] && !pe_write[s]) er[s] = 1;
        if (win < 0 && pe_valid[s] && pe_write[s]) win = s;
      end
      eoutv = (win >= 0);
      if (win >= 0) begin eoutd = wd_of(win); er[win] = out_ready; end
    end else begin
      for (int s = 0; s < N; s++) begin
        if (pe_valid[s] && pe_write[s]) begin
          er[s] = 1; p_pub[s] = 1; p_pubd[s] = wd_of(s);
        end else if (pe_valid[s]) begin
          er[s] = pv[tid_of(s)]; erd[s] = pd[tid_of(s)];
        end
      end
    end

    for (int s = 0; s < N; s++) begin
      chk(pe_ready[s] == er[s], $sformatf("pe%0d ready", s), 64'(pe_ready[s]), 64'(er[s]));
      if (er[s] && !pe_write[s])
        chk(pe_rdata[s*DW +: DW] == erd[s], $sformatf("pe%0d rdata", s),
            64'(pe_rdata[s*DW +: DW]), 64'(erd[s]));
    end
    chk(ctl_ready == ecr, "ctl_ready", 64'(ctl_ready), 64'(ecr));
    chk(in_ready == einr, "in_ready", 64'(in_ready), 64'(einr));
    chk(out_valid == eoutv, "out_valid", 64'(out_valid), 64'(eoutv));
    if (eoutv) chk(out_data == eoutd, "out_data", 64'(out_data), 64'(eoutd));
  endtask

  task automatic apply_update();
    md = p_mode;
    for (int s = 0; s < N; s++) if (p_drain[s]) mfull[s] = 0;
    for (int d = 0; d < N; d++)
      if (p_load[d]) begin
        mfull[d] = 1; mdata[d] = p_ldd[d]; msrc[d] = p_lds[d]; mctl[d] = p_ldc[d];
      end
    for (int s = 0; s < N; s++) if (p_pub[s]) begin pv[s] = 1; pd[s] = p_pubd[s]; end
  endtask

  // inputs are set at a falling edge; compare, then let the rising edge pass
  task automatic cyc();
    #1;
    eval_check();
    @(posedge clk);
    apply_update();
    @(negedge clk);
  endtask

  task automatic idle();
    ctl_valid = 0; ctl_addr = '0; ctl_wdata = '0;
    pe_valid = '0; pe_write = '0; pe_addr = '0; pe_wdata = '0;
    in_valid = 0; in_data = '0; out_ready = 0;
  endtask

  task automatic pe(int s, bit w, int id, logic [DW-1:0] d);
    pe_valid[s] = 1; pe_write[s] = w;
    pe_addr[s*AW +: AW] = AW'((id << OFS) | 8'h5A);
    pe_wdata[s*DW +: DW] = d;
  endtask

  task automatic set_mode(int m);
    idle();
    ctl_valid = 1; ctl_addr = MA; ctl_wdata = DW'(m);
    cyc();
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    md = 0;
    for (int s = 0; s < N; s++) begin mfull[s] = 0; pv[s] = 0; msrc[s] = 0; mctl[s] = 0; end
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: receive right after reset stalls; broadcast slot also empty
    cur_req = "R1";
    pe(0, 0, 1, 0); cyc(); idle();

    // R3 / R5: send, wrong-source receive stalls, right source receives
    cur_req = "R3";
    pe(1, 1, 2, 32'hA1A1_0001); cyc(); idle();
    cur_req = "R5";
    pe(2, 0, 0, 0); cyc(); idle();
    cur_req = "R3";
    pe(2, 0, 1, 0); cyc(); idle();

    // R4: contention, then drain and refill in one cycle
    cur_req = "R4";
    pe(1, 1, 0, 32'hB0B0_0001); pe(3, 1, 0, 32'hB0B0_0003); cyc();
    idle(); pe(3, 1, 0, 32'hB0B0_0003); pe(0, 0, 1, 0); cyc();
    idle(); pe(0, 0, 3, 0); cyc(); idle();

    // R6: every PE sends to its neighbour in one cycle
    cur_req = "R6";
    for (int s = 0; s < N; s++) pe(s, 1, (s + 1) % N, 32'hC0C0_0000 + s);
    cyc(); idle();
    for (int s = 0; s < N; s++) pe(s, 0, (s + N - 1) % N, 0);
    cyc(); idle();

    // R2: illegal mode ignored, then mode 1
    cur_req = "R2";
    set_mode(7);
    pe(0, 1, 1, 32'hD0D0_0000); cyc(); idle();   // still mode 0: delivered
    pe(1, 0, 0, 0); cyc(); idle();
    set_mode(1);

    // R7 / R11: controller to PE, PE send discarded
    cur_req = "R7";
    ctl_valid = 1; ctl_addr = 16'h0200; ctl_wdata = 32'hE0E0_0002; cyc(); idle();
    ctl_valid = 1; ctl_addr = 16'h0200; ctl_wdata = 32'hE0E0_0003; cyc(); idle();
    pe(2, 0, 3, 0); cyc(); idle();
    cur_req = "R11";
    pe(0, 1, 3, 32'hF0F0_0000); cyc(); idle();
    pe(3, 0, 0, 0); cyc(); idle();

    // R8: input device
    set_mode(2);
    cur_req = "R8";
    pe(1, 0, 0, 0); pe(2, 0, 0, 0); in_valid = 1; in_data = 32'h1234_5678; cyc();
    in_valid = 0; cyc();
    idle(); pe(2, 0, 0, 0); in_valid = 1; in_data = 32'h8765_4321; cyc(); idle();
    cur_req = "R11";
    pe(0, 1, 0, 32'h5555_0000); cyc(); idle();

    // R9: output device
    set_mode(3);
    cur_req = "R9";
    pe(2, 1, 0, 32'h9999_0002); pe(3, 1, 0, 32'h9999_0003); cyc();
    out_ready = 1; cyc();
    idle(); pe(3, 1, 0, 32'h9999_0003); out_ready = 1; cyc(); idle();
    cur_req = "R11";
    pe(1, 0, 0, 0); cyc(); idle();

    // R10: broadcast-read
    set_mode(4);
    cur_req = "R10";
    pe(1, 0, 3, 0); cyc(); idle();
    pe(3, 1, 0, 32'h7777_0003); cyc(); idle();
    pe(0, 0, 3, 0); pe(1, 0, 3, 0); pe(2, 0, 3, 0); cyc(); cyc(); idle();
    cur_req = "R11";
    ctl_valid = 1; ctl_addr = 16'h0100; ctl_wdata = 32'h1; cyc(); idle();

    // random traffic in every mode
    for (int m = 0; m < 5; m++) begin
      set_mode(m);
      case (m)
        0: cur_req = "R3/R4/R5/R6";
        1: cur_req = "R7";
        2: cur_req = "R8";
        3: cur_req = "R9";
        default: cur_req = "R10";
      endcase
      repeat (300) begin
        for (int s = 0; s < N; s++) begin
          if ($urandom_range(0, 2) != 0) pe(s, 1'($urandom_range(0, 1)), $urandom_range(0, N - 1), $urandom);
          else begin pe_valid[s] = 0; pe_write[s] = 0; end
        end
        ctl_valid = 1'($urandom_range(0, 1));
        ctl_addr = {1'b0, 15'($urandom)};
        ctl_wdata = $urandom;
        in_valid = 1'($urandom_range(0, 1));
        in_data = $urandom;
        out_ready = 1'($urandom_range(0, 1));
        cyc();
      end
      idle();
    end

    finish_run();
  end

endmodule